// File: doc/BRIEF.md
# I2C Receive Wait and Interrupt Sequencer

This block decides when a byte-wide I2C engine raises its interrupt and when it stretches SCL low. It watches SCL falling-edge events together with the engine's bit position, and START and STOP detect pulses. It also sees write strobes for three software registers. The data shift register write resumes a transfer. The clock control write carries the ACK mode bit. The control write carries the STOP interrupt enable, the early-receive interrupt enable and a pending flag that software can only set to 1.

In ACK-mode receive the block can halt the bus at two points in one byte. The first is an optional early halt after the last data bit, taken before the ACK clock runs. The second is the normal halt after the ACK clock. An internal wait flag tells software which of the two halts raised the interrupt. Software reads this flag at the position of the early-receive enable bit. At each halt the pending flag goes to 0 and SCL is held low until software resumes the transfer in the way that halt requires. The transmit direction and the address byte that follows START only ever use the post-ACK halt.

Top module: `i2c_rwc_top`

## Requirements
- R1: After reset, pend_n is 1 (nothing pending), wait_flag is 0, scl_hold is 0, ack_clk_en is 1 and irq is 0.
- R2: A stop_det pulse with the STOP enable set makes irq high for exactly the next cycle and leaves pend_n unchanged. With the enable clear, a STOP raises no irq.
- R3: An SCL fall at bit_pos 8 (the ACK slot) while running gives, one cycle later, a one-cycle irq, pend_n at 0 and scl_hold at 1.
- R4: An SCL fall at bit_pos 7 (last data bit) starts the early halt when all of these hold: is_rx is 1, the byte is not the address byte, the ACK bit is 1, the early enable is 1 and wait_flag is 1. One cycle later irq pulses, pend_n is 0, scl_hold is 1 and ack_clk_en is 0.
- R5: With the ACK bit at 0, an SCL fall at bit_pos 7 never starts the early halt, even when the early enable is 1.
- R6: During an early halt, a control write with pend set to 1 has no effect until a clock control write has occurred. After that write, such a control write restores pend_n to 1, scl_hold to 0 and ack_clk_en to 1 on the next cycle.
- R7: A data shift write sets wait_flag when is_rx is 1, the byte is not the address byte, the ACK bit is 1 and the early enable is 1. A clock control write clears wait_flag.
- R8: In transmit (is_rx 0), and for the address byte after START, a data shift write leaves wait_flag at 0 and bit_pos 7 raises no irq. The ACK slot still interrupts.
- R9: During a post-ACK halt, a data shift write sets pend_n to 1 and clears scl_hold on the next cycle.
- R10: A start_det or stop_det pulse clears wait_flag and releases scl_hold on the next cycle. A START marks the next byte as the address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_fall | input | 1 | One-cycle pulse per SCL falling edge |
| bit_pos | input | 4 | Bit that just completed: 0..7 data, 8 ACK slot |
| is_rx | input | 1 | 1 = receive direction, 0 = transmit |
| start_det | input | 1 | START condition detect pulse |
| stop_det | input | 1 | STOP condition detect pulse |
| wr_data | input | 1 | Data shift register write strobe |
| wr_clkctl | input | 1 | Clock control register write strobe |
| clkctl_ack | input | 1 | ACK mode bit written with wr_clkctl |
| wr_ctrl | input | 1 | Control register write strobe |
| ctrl_pend | input | 1 | Pending flag bit written with wr_ctrl (only 1 acts) |
| ctrl_stop_ie | input | 1 | STOP interrupt enable written with wr_ctrl |
| ctrl_early_ie | input | 1 | Early-receive interrupt enable written with wr_ctrl |
| irq | output | 1 | One-cycle interrupt request pulse |
| pend_n | output | 1 | Pending flag, 0 = interrupt pending |
| scl_hold | output | 1 | Hold SCL low |
| ack_clk_en | output | 1 | 0 suppresses the ACK clock |
| wait_flag | output | 1 | Internal wait flag, read at the early-enable bit |

## Verification
The assertions assume that bus events and register writes do not land in the same cycle, except for the cases where the design gives START and STOP priority. They also assume the ACK-slot edge never arrives during an early halt, because that halt suppresses the ACK clock. The stimulus drives each strobe in a cycle of its own. It sends SCL falls only while the bus is running, and it resumes every halt by the method that halt requires before the next bit is clocked.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
  typedef enum logic [1:0] {
    PT_RUN   = 2'd0,
    PT_EARLY = 2'd1,
    PT_POST  = 2'd2
  } stop_pt_e;

  function automatic int unsigned last_data_idx(input int unsigned nbits);
    return nbits - 1;
  endfunction

  function automatic int unsigned ack_idx(input int unsigned nbits);
    return nbits;
  endfunction
endpackage

// File: rtl/rwc_cfg_regs.sv
module rwc_cfg_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_clkctl,
  input  logic clkctl_ack,
  input  logic wr_ctrl,
  input  logic ctrl_stop_ie,
  input  logic ctrl_early_ie,
  output logic ack_mode,
  output logic stop_ie,
  output logic early_ie
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_mode <= 1'b0;
      stop_ie  <= 1'b0;
      early_ie <= 1'b0;
    end else begin
      if (wr_clkctl) ack_mode <= clkctl_ack;
      if (wr_ctrl) begin
        stop_ie  <= ctrl_stop_ie;
        early_ie <= ctrl_early_ie;
      end
    end
  end
endmodule

// File: rtl/rwc_event_decode.sv
module rwc_event_decode
  import rwc_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  localparam int unsigned POS_W = $clog2(DATA_BITS + 1)
) (
  input  logic             scl_fall,
  input  logic [POS_W-1:0] bit_pos,
  input  logic             is_rx,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             first_byte,
  input  logic             wait_flag,
  input  logic             ack_mode,
  input  logic             early_ie,
  input  logic             stop_ie,
  input  stop_pt_e         stop_pt,
  output logic             ev_bus,
  output logic             ev_early,
  output logic             ev_ack,
  output logic             ev_stop_irq
);
  localparam int unsigned LAST_POS = last_data_idx(DATA_BITS);
  localparam int unsigned ACK_POS  = ack_idx(DATA_BITS);

  logic at_last, at_ack, running;

  always_comb begin
    ev_bus      = start_det | stop_det;
    running     = (stop_pt == PT_RUN) && !ev_bus;
    at_last     = scl_fall && (bit_pos == POS_W'(LAST_POS));
    at_ack      = scl_fall && (bit_pos == POS_W'(ACK_POS));
    ev_early    = running && at_last && is_rx && !first_byte
                  && wait_flag && ack_mode && early_ie;
    ev_ack      = running && at_ack;
    ev_stop_irq = stop_det && stop_ie;
  end
endmodule

// File: rtl/rwc_wait_track.sv
module rwc_wait_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic ev_bus,
  input  logic ev_ack,
  input  logic wr_data,
  input  logic wr_clkctl,
  input  logic is_rx,
  input  logic ack_mode,
  input  logic early_ie,
  output logic wait_flag,
  output logic first_byte
);
  logic arm_ok;
  assign arm_ok = is_rx && !first_byte && ack_mode && early_ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_flag  <= 1'b0;
      first_byte <= 1'b0;
    end else if (ev_bus) begin
      wait_flag  <= 1'b0;
      first_byte <= start_det;
    end else begin
      if (wr_clkctl)              wait_flag <= 1'b0;
      else if (wr_data && arm_ok) wait_flag <= 1'b1;
      if (ev_ack) first_byte <= 1'b0;
    end
  end
endmodule

// File: rtl/rwc_stop_ctrl.sv
module rwc_stop_ctrl
  import rwc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ev_bus,
  input  logic     ev_early,
  input  logic     ev_ack,
  input  logic     ev_stop_irq,
  input  logic     wr_data,
  input  logic     wr_clkctl,
  input  logic     wr_ctrl,
  input  logic     ctrl_pend,
  output stop_pt_e stop_pt,
  output logic     cc_written,
  output logic     pend_n,
  output logic     irq
);
  logic set_req, resume_early, resume_post;

  always_comb begin
    set_req      = wr_ctrl && ctrl_pend;
    resume_early = (stop_pt == PT_EARLY) && set_req && cc_written;
    resume_post  = (stop_pt == PT_POST) && (wr_data || set_req);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_pt    <= PT_RUN;
      cc_written <= 1'b0;
      pend_n     <= 1'b1;
      irq        <= 1'b0;
    end else begin
      irq <= ev_early | ev_ack | ev_stop_irq;
      if (ev_bus) begin
        stop_pt    <= PT_RUN;
        cc_written <= 1'b0;
      end else if (ev_early) begin
        stop_pt    <= PT_EARLY;
        cc_written <= 1'b0;
        pend_n     <= 1'b0;
      end else if (ev_ack) begin
        stop_pt <= PT_POST;
        pend_n  <= 1'b0;
      end else if (resume_early) begin
        stop_pt    <= PT_RUN;
        cc_written <= 1'b0;
        pend_n     <= 1'b1;
      end else if (resume_post) begin
        stop_pt <= PT_RUN;
        pend_n  <= 1'b1;
      end else begin
        if ((stop_pt == PT_EARLY) && wr_clkctl) cc_written <= 1'b1;
        if ((stop_pt == PT_RUN) && set_req)     pend_n     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_rwc_top.sv
module i2c_rwc_top
  import rwc_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  localparam int unsigned POS_W = $clog2(DATA_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_fall,
  input  logic [POS_W-1:0] bit_pos,
  input  logic             is_rx,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             wr_data,
  input  logic             wr_clkctl,
  input  logic             clkctl_ack,
  input  logic             wr_ctrl,
  input  logic             ctrl_pend,
  input  logic             ctrl_stop_ie,
  input  logic             ctrl_early_ie,
  output logic             irq,
  output logic             pend_n,
  output logic             scl_hold,
  output logic             ack_clk_en,
  output logic             wait_flag
);
  logic     ack_mode, stop_ie, early_ie;
  logic     first_byte, cc_written;
  logic     ev_bus, ev_early, ev_ack, ev_stop_irq;
  stop_pt_e stop_pt;

  rwc_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_clkctl(wr_clkctl), .clkctl_ack(clkctl_ack),
    .wr_ctrl(wr_ctrl), .ctrl_stop_ie(ctrl_stop_ie), .ctrl_early_ie(ctrl_early_ie),
    .ack_mode(ack_mode), .stop_ie(stop_ie), .early_ie(early_ie)
  );

  rwc_event_decode #(.DATA_BITS(DATA_BITS)) u_dec (
    .scl_fall(scl_fall), .bit_pos(bit_pos), .is_rx(is_rx),
    .start_det(start_det), .stop_det(stop_det),
    .first_byte(first_byte), .wait_flag(wait_flag),
    .ack_mode(ack_mode), .early_ie(early_ie), .stop_ie(stop_ie),
    .stop_pt(stop_pt),
    .ev_bus(ev_bus), .ev_early(ev_early), .ev_ack(ev_ack), .ev_stop_irq(ev_stop_irq)
  );

  rwc_wait_track u_wait (
    .clk(clk), .rst_n(rst_n),
    .start_det(start_det), .ev_bus(ev_bus), .ev_ack(ev_ack),
    .wr_data(wr_data), .wr_clkctl(wr_clkctl), .is_rx(is_rx),
    .ack_mode(ack_mode), .early_ie(early_ie),
    .wait_flag(wait_flag), .first_byte(first_byte)
  );

  rwc_stop_ctrl u_stop (
    .clk(clk), .rst_n(rst_n),
    .ev_bus(ev_bus), .ev_early(ev_early), .ev_ack(ev_ack), .ev_stop_irq(ev_stop_irq),
    .wr_data(wr_data), .wr_clkctl(wr_clkctl), .wr_ctrl(wr_ctrl), .ctrl_pend(ctrl_pend),
    .stop_pt(stop_pt), .cc_written(cc_written), .pend_n(pend_n), .irq(irq)
  );

  assign scl_hold   = (stop_pt != PT_RUN) && !pend_n;
  assign ack_clk_en = (stop_pt != PT_EARLY);
endmodule

// File: rtl/rwc_checker.sv
module rwc_checker
  import rwc_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     start_det,
  input logic     stop_det,
  input logic     wr_data,
  input logic     wr_clkctl,
  input logic     irq,
  input logic     pend_n,
  input logic     scl_hold,
  input logic     ack_clk_en,
  input logic     wait_flag,
  input logic     ack_mode,
  input logic     early_ie,
  input logic     first_byte,
  input logic     cc_written,
  input stop_pt_e stop_pt
);
  AST_PEND_FALL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_n) |-> irq); // R3
  AST_STOP_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> $stable(pend_n)); // R2
  AST_EARLY_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_clk_en) |-> ($past(ack_mode) && $past(early_ie))); // R5
  AST_EARLY_RESUME_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_clk_en) && !$past(start_det) && !$past(stop_det)) |-> $past(cc_written)); // R6
  AST_WAIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clkctl |=> !wait_flag); // R7
  AST_ADDR_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    first_byte |-> !wait_flag); // R8
  AST_POST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    ((stop_pt == PT_POST) && wr_data && !start_det && !stop_det) |=> !scl_hold); // R9
  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> (!scl_hold && !wait_flag)); // R10
endmodule

bind i2c_rwc_top rwc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
  .wr_data(wr_data), .wr_clkctl(wr_clkctl), .irq(irq), .pend_n(pend_n),
  .scl_hold(scl_hold), .ack_clk_en(ack_clk_en), .wait_flag(wait_flag),
  .ack_mode(ack_mode), .early_ie(early_ie), .first_byte(first_byte),
  .cc_written(cc_written), .stop_pt(stop_pt)
);

// File: tb/tb_i2c_rwc_top.sv
module tb_i2c_rwc_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_fall = 0, is_rx = 0, start_det = 0, stop_det = 0;
  logic wr_data = 0, wr_clkctl = 0, clkctl_ack = 0;
  logic wr_ctrl = 0, ctrl_pend = 0, ctrl_stop_ie = 0, ctrl_early_ie = 0;
  logic [3:0] bit_pos = 0;
  logic irq, pend_n, scl_hold, ack_clk_en, wait_flag;

  int checks = 0, failures = 0;

  // behavioural reference state
  int m_pend = 1, m_wait = 0, m_first = 0, m_halt = 0, m_cc = 0; // halt: 0 run, 1 early, 2 post
  int m_ackm = 0, m_sie = 0, m_eie = 0, m_irq = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_rwc_top dut (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .bit_pos(bit_pos), .is_rx(is_rx),
    .start_det(start_det), .stop_det(stop_det), .wr_data(wr_data),
    .wr_clkctl(wr_clkctl), .clkctl_ack(clkctl_ack), .wr_ctrl(wr_ctrl),
    .ctrl_pend(ctrl_pend), .ctrl_stop_ie(ctrl_stop_ie), .ctrl_early_ie(ctrl_early_ie),
    .irq(irq), .pend_n(pend_n), .scl_hold(scl_hold), .ack_clk_en(ack_clk_en),
    .wait_flag(wait_flag)
  );

  always @(posedge clk) begin
    int o_first;
    o_first = m_first;
    m_irq = 0;
    if (!rst_n) begin
      m_pend = 1; m_wait = 0; m_first = 0; m_halt = 0; m_cc = 0;
      m_ackm = 0; m_sie = 0; m_eie = 0;
    end else begin
      if (start_det || stop_det) begin
        if (stop_det && m_sie != 0) m_irq = 1;
        m_halt = 0; m_cc = 0; m_wait = 0;
        m_first = start_det ? 1 : 0;
      end else begin
        if (scl_fall && bit_pos == 7 && m_halt == 0 && is_rx && o_first == 0
            && m_wait == 1 && m_ackm == 1 && m_eie == 1) begin
          m_halt = 1; m_pend = 0; m_cc = 0; m_irq = 1;
        end else if (scl_fall && bit_pos == 8 && m_halt == 0) begin
          m_halt = 2; m_pend = 0; m_irq = 1; m_first = 0;
        end else if (m_halt == 1 && wr_ctrl && ctrl_pend && m_cc == 1) begin
          m_halt = 0; m_pend = 1; m_cc = 0;
        end else if (m_halt == 2 && (wr_data || (wr_ctrl && ctrl_pend))) begin
          m_halt = 0; m_pend = 1;
        end else begin
          if (m_halt == 1 && wr_clkctl) m_cc = 1;
          if (m_halt == 0 && wr_ctrl && ctrl_pend) m_pend = 1;
        end
        if (wr_clkctl) m_wait = 0;
        else if (wr_data && is_rx && o_first == 0 && m_ackm == 1 && m_eie == 1) m_wait = 1;
      end
      if (wr_clkctl) m_ackm = clkctl_ack;
      if (wr_ctrl) begin m_sie = ctrl_stop_ie; m_eie = ctrl_early_ie; end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // compare against the reference on every clock
  always @(negedge clk) if (rst_n) begin
    chk("R3", "model pend_n", int'(pend_n), m_pend);
    chk("R2", "model irq", int'(irq), m_irq);
    chk("R9", "model scl_hold", int'(scl_hold), (m_halt != 0 && m_pend == 0) ? 1 : 0);
    chk("R4", "model ack_clk_en", int'(ack_clk_en), (m_halt != 1) ? 1 : 0);
    chk("R7", "model wait_flag", int'(wait_flag), m_wait);
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask
  task automatic fall(input int pos);
    bit_pos = 4'(pos); scl_fall = 1; tick(); scl_fall = 0;
  endtask
  task automatic fall_bits(input int from, input int to);
    for (int i = from; i <= to; i++) begin fall(i); tick(); end
  endtask
  task automatic w_ctrl(input logic p, input logic sie, input logic eie);
    wr_ctrl = 1; ctrl_pend = p; ctrl_stop_ie = sie; ctrl_early_ie = eie; tick(); wr_ctrl = 0;
  endtask
  task automatic w_cc(input logic a);
    wr_clkctl = 1; clkctl_ack = a; tick(); wr_clkctl = 0;
  endtask
  task automatic w_data();
    wr_data = 1; tick(); wr_data = 0;
  endtask
  task automatic p_start();
    start_det = 1; tick(); start_det = 0;
  endtask
  task automatic p_stop();
    stop_det = 1; tick(); stop_det = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1", "reset pend_n", int'(pend_n), 1);
    chk("R1", "reset wait_flag", int'(wait_flag), 0);
    chk("R1", "reset scl_hold", int'(scl_hold), 0);
    chk("R1", "reset ack_clk_en", int'(ack_clk_en), 1);
    chk("R1", "reset irq", int'(irq), 0);
    rst_n = 1; tick();

    w_ctrl(1, 1, 1); w_cc(1); is_rx = 1;
    // address byte in receive direction
    p_start();
    w_data();
    chk("R8", "address byte data write wait_flag", int'(wait_flag), 0);
    fall_bits(0, 6);
    fall(7);
    chk("R8", "address byte bit7 irq", int'(irq), 0);
    tick();
    fall(8);
    chk("R3", "ack irq", int'(irq), 1);
    chk("R3", "ack pend_n", int'(pend_n), 0);
    chk("R3", "ack scl_hold", int'(scl_hold), 1);
    tick();
    chk("R3", "irq single cycle", int'(irq), 0);
    w_data();
    chk("R9", "post resume scl_hold", int'(scl_hold), 0);
    chk("R7", "data write sets wait_flag", int'(wait_flag), 1);

    // data byte with early halt
    fall_bits(0, 6);
    fall(7);
    chk("R4", "early irq", int'(irq), 1);
    chk("R4", "early scl_hold", int'(scl_hold), 1);
    chk("R4", "early ack_clk_en", int'(ack_clk_en), 0);
    tick();
    w_ctrl(1, 1, 1);
    chk("R6", "pend write before clkctl ignored", int'(scl_hold), 1);
    w_cc(1);
    chk("R7", "clkctl clears wait_flag", int'(wait_flag), 0);
    chk("R6", "still held after clkctl", int'(scl_hold), 1);
    w_ctrl(1, 1, 1);
    chk("R6", "early resume scl_hold", int'(scl_hold), 0);
    chk("R6", "early resume ack_clk_en", int'(ack_clk_en), 1);
    chk("R6", "early resume pend_n", int'(pend_n), 1);
    fall(8);
    chk("R3", "second irq after ack", int'(irq), 1);
    chk("R7", "wait_flag reads 0 at post stop", int'(wait_flag), 0);
    tick();
    w_data();
    chk("R9", "post resume pend_n", int'(pend_n), 1);

    // NACK mode: no early halt
    w_cc(0); w_data();
    fall_bits(0, 6);
    fall(7);
    chk("R5", "nack bit7 irq", int'(irq), 0);
    chk("R5", "nack ack_clk_en", int'(ack_clk_en), 1);
    tick();
    fall(8); tick(); w_data();

    // transmit: no early halt
    w_cc(1); is_rx = 0; w_data();
    chk("R8", "transmit data write wait_flag", int'(wait_flag), 0);
    fall_bits(0, 6);
    fall(7);
    chk("R8", "transmit bit7 irq", int'(irq), 0);
    tick();
    fall(8);
    chk("R8", "transmit ack irq", int'(irq), 1);
    tick();

    // STOP while held, wait flag set beforehand
    is_rx = 1; w_data(); // resumes post halt, arms wait
    chk("R7", "wait armed", int'(wait_flag), 1);
    fall_bits(0, 6); fall(7); tick();
    chk("R4", "held before stop", int'(scl_hold), 1);
    p_stop();
    chk("R2", "stop irq", int'(irq), 1);
    chk("R2", "stop leaves pend_n", int'(pend_n), 0);
    chk("R10", "stop releases hold", int'(scl_hold), 0);
    chk("R10", "stop clears wait", int'(wait_flag), 0);
    tick();
    w_ctrl(1, 0, 1);
    p_stop();
    chk("R2", "stop without enable irq", int'(irq), 0);

    // START clears wait flag
    p_start(); fall_bits(0, 8); w_data();
    chk("R7", "wait armed again", int'(wait_flag), 1);
    p_start();
    chk("R10", "start clears wait", int'(wait_flag), 0);
    tick(); tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule